// File: doc/BRIEF.md
# Upper Window Bank Mapper

This block turns a CPU access to the top half of a 64K Z80-style address space into an 8K physical page number and a target memory. A legacy bank-select I/O port writes an 8-bit register. Five of its bits form a 16K bank number. The bank is split into two consecutive 8K pages. The even page is shown at 0xC000-0xDFFF and the odd page at 0xE000-0xFFFF. The pages come from a 512K SRAM pool of 64 pages. Two bank codes are sent instead to a 4-page dual-ported video RAM. The 0x8000-0xBFFF window is fixed to two SRAM pages.

A compatibility input limits banking to the first 128K by masking the two high bank bits. A sideways-overlay input per upper slot lets a neighbouring block claim 0xC000 or 0xE000. When it does, its own page number wins over the port mapping.

The mapping is combinational from the address and the register, so the result is valid in the same cycle as the address. No data stream passes through the block. It therefore has no valid/ready handshake and never applies back-pressure. Every pin is a plain control or status signal.

Top module: `upper_window_mapper`

## Requirements
- R1: After reset the bank register is 0x00, so 0xC000-0xDFFF maps to SRAM page 0 and 0xE000-0xFFFF maps to SRAM page 1.
- R2: The register loads `io_wdata` on a clock edge where `io_wr` is high and `io_addr` equals the port address (default 0x7FFD). A write to any other address leaves the mapping unchanged.
- R3: The bank number N is {d7, d6, d2, d1, d0} of the register, with d7 as the MSB. Register bits 5:3 have no effect. With target SRAM (code 0), the slot at 0xC000 maps to page 2N and the slot at 0xE000 maps to page 2N+1.
- R4: Bank 5 maps to video RAM (code 1) pages 0 and 1. Bank 7 maps to video RAM pages 2 and 3. Banks 13, 15, 21 and the others with a nonzero high pair stay in SRAM.
- R5: While `limit_128k` is high, register bits 7:6 are treated as zero. The flag acts at once, without a new port write.
- R6: 0x8000-0x9FFF maps to SRAM page 4 and 0xA000-0xBFFF maps to SRAM page 5, whatever the register holds.
- R7: When `side_lo_en` or `side_hi_en` is high, the slot at 0xC000 or 0xE000 reports target code 2 with the page taken from `side_lo_page` or `side_hi_page`. The other slot is unaffected.
- R8: For addresses below 0x8000, `map_hit` is 0 and `map_tgt` and `map_page` are 0.
- R9: The outputs follow a change of `cpu_addr` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | CPU I/O write strobe |
| io_addr | input | 16 | CPU I/O address |
| io_wdata | input | 8 | CPU I/O write data |
| limit_128k | input | 1 | Compatibility flag: mask bank bits 7:6 |
| cpu_addr | input | 16 | CPU memory address |
| side_lo_en | input | 1 | Overlay claims the 0xC000 slot |
| side_lo_page | input | 6 | Overlay page for the 0xC000 slot |
| side_hi_en | input | 1 | Overlay claims the 0xE000 slot |
| side_hi_page | input | 6 | Overlay page for the 0xE000 slot |
| map_hit | output | 1 | Address lies in 0x8000-0xFFFF |
| map_tgt | output | 2 | Target: 0 SRAM, 1 video RAM, 2 overlay |
| map_page | output | 6 | Physical 8K page index in the target |

## Verification
The hardest case to reach is the interaction between the compatibility flag and a register whose high pair is nonzero. An example is value 0xC7. It is SRAM page 63 with the flag low, but video page 3 with the flag high. It can only be seen by toggling the flag between clock edges after one port write. The stimulus loads such values once and then flips `limit_128k` and `cpu_addr` between edges. This also shows that both the flag and the address act combinationally. Overlay checks enable one slot at a time, so that leakage into the other slot would be visible.

// File: rtl/upw_pkg.sv
package upw_pkg;
  typedef enum logic [1:0] {
    TGT_SRAM = 2'd0,
    TGT_VRAM = 2'd1,
    TGT_SIDE = 2'd2
  } tgt_e;
endpackage

// File: rtl/upw_bank_reg.sv
module upw_bank_reg #(
  parameter int          DW         = 8,
  parameter int          AW         = 16,
  parameter logic [15:0] PORT_MATCH = 16'h7FFD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] bank_q
);
  logic sel_hit;
  assign sel_hit = io_wr && (io_addr == PORT_MATCH[AW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else if (sel_hit) bank_q <= io_wdata;
  end

  // R1: reset clears the register
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (bank_q == '0));
  // R2: a decoded write loads the data
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |=> (bank_q == $past(io_wdata)));
  // R2: no decoded write, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit |=> $stable(bank_q));
endmodule

// File: rtl/upw_bank_decode.sv
module upw_bank_decode #(
  parameter int DW      = 8,
  parameter int PAGE_W  = 6,
  parameter int VPAGE_W = 2
) (
  input  logic [DW-1:0]      bank_q,
  input  logic               limit_128k,
  output logic [PAGE_W-1:0]  even_page,
  output logic               vram_sel,
  output logic [VPAGE_W-1:0] vram_even
);
  localparam int BANK_W = PAGE_W - 1;
  localparam int HI_W   = BANK_W - 3;

  logic [HI_W-1:0]   hi_bits;
  logic [2:0]        lo_bits;
  logic [BANK_W-1:0] bank_n;
  logic              unused_mid;

  assign unused_mid = ^bank_q[DW-HI_W-1:3];
  assign hi_bits    = limit_128k ? '0 : bank_q[DW-1 -: HI_W];
  assign lo_bits    = bank_q[2:0];
  assign bank_n     = {hi_bits, lo_bits};
  assign even_page  = {bank_n, 1'b0};

  // video RAM answers for low codes 5 and 7 when the high pair is clear
  assign vram_sel  = (hi_bits == '0) && lo_bits[2] && lo_bits[0];
  assign vram_even = {lo_bits[1], {(VPAGE_W-1){1'b0}}};

  always_comb begin
    // R4: a video RAM hit only comes from bank 5 or 7
    a_r4_vram_codes: assert (!vram_sel || (bank_n == 5) || (bank_n == 7));
    // R5: the flag clears the high pair
    a_r5_limit_low: assert (!limit_128k || (even_page[PAGE_W-1 -: HI_W] == '0));
  end
endmodule

// File: rtl/upw_slot_select.sv
module upw_slot_select
  import upw_pkg::*;
#(
  parameter int PAGE_W   = 6,
  parameter int VPAGE_W  = 2,
  parameter int FIXED_PG = 4
) (
  input  logic [2:0]         addr_top,
  input  logic [PAGE_W-1:0]  even_page,
  input  logic               vram_sel,
  input  logic [VPAGE_W-1:0] vram_even,
  input  logic               side_lo_en,
  input  logic [PAGE_W-1:0]  side_lo_page,
  input  logic               side_hi_en,
  input  logic [PAGE_W-1:0]  side_hi_page,
  output logic               map_hit,
  output tgt_e               map_tgt,
  output logic [PAGE_W-1:0]  map_page
);
  localparam logic [PAGE_W-1:0] FIX_EVEN = PAGE_W'(FIXED_PG);

  logic odd;
  logic upper;
  logic side_on;
  logic [PAGE_W-1:0] side_pg;

  assign odd     = addr_top[0];
  assign upper   = addr_top[2] && addr_top[1];
  assign side_on = odd ? side_hi_en : side_lo_en;
  assign side_pg = odd ? side_hi_page : side_lo_page;

  always_comb begin
    map_hit  = addr_top[2];
    map_tgt  = TGT_SRAM;
    map_page = '0;
    if (addr_top[2]) begin
      if (!upper) begin
        map_page = FIX_EVEN | PAGE_W'(odd);
      end else if (side_on) begin
        map_tgt  = TGT_SIDE;
        map_page = side_pg;
      end else if (vram_sel) begin
        map_tgt  = TGT_VRAM;
        map_page = {{(PAGE_W-VPAGE_W){1'b0}}, vram_even | VPAGE_W'(odd)};
      end else begin
        map_page = even_page | PAGE_W'(odd);
      end
    end
  end

  always_comb begin
    // R7: an enabled overlay wins its slot
    a_r7_side_wins: assert (!(upper && side_on) || (map_tgt == TGT_SIDE));
    // R8: nothing reported below the window
    a_r8_no_hit_low: assert (addr_top[2] || (map_tgt == TGT_SRAM && map_page == '0));
    // R3: non-overlay pages keep the slot parity
    a_r3_parity: assert (!map_hit || (map_tgt == TGT_SIDE) || (map_page[0] == odd));
  end
endmodule

// File: rtl/upper_window_mapper.sv
module upper_window_mapper
  import upw_pkg::*;
#(
  parameter int          PAGE_W     = 6,
  parameter int          VPAGE_W    = 2,
  parameter logic [15:0] PORT_MATCH = 16'h7FFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              limit_128k,
  input  logic [15:0]       cpu_addr,
  input  logic              side_lo_en,
  input  logic [PAGE_W-1:0] side_lo_page,
  input  logic              side_hi_en,
  input  logic [PAGE_W-1:0] side_hi_page,
  output logic              map_hit,
  output logic [1:0]        map_tgt,
  output logic [PAGE_W-1:0] map_page
);
  localparam int DW = 8;

  logic [DW-1:0]      bank_q;
  logic [PAGE_W-1:0]  even_page;
  logic               vram_sel;
  logic [VPAGE_W-1:0] vram_even;
  tgt_e               tgt;
  logic               unused_addr_low;

  assign unused_addr_low = ^cpu_addr[12:0];

  upw_bank_reg #(.DW(DW), .AW(16), .PORT_MATCH(PORT_MATCH)) u_reg (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .bank_q(bank_q)
  );

  upw_bank_decode #(.DW(DW), .PAGE_W(PAGE_W), .VPAGE_W(VPAGE_W)) u_dec (
    .bank_q(bank_q), .limit_128k(limit_128k), .even_page(even_page),
    .vram_sel(vram_sel), .vram_even(vram_even)
  );

  upw_slot_select #(.PAGE_W(PAGE_W), .VPAGE_W(VPAGE_W), .FIXED_PG(4)) u_sel (
    .addr_top(cpu_addr[15:13]), .even_page(even_page), .vram_sel(vram_sel),
    .vram_even(vram_even), .side_lo_en(side_lo_en), .side_lo_page(side_lo_page),
    .side_hi_en(side_hi_en), .side_hi_page(side_hi_page),
    .map_hit(map_hit), .map_tgt(tgt), .map_page(map_page)
  );

  assign map_tgt = tgt;

  // R6: the middle window is always SRAM page 4 or 5
  a_r6_fixed_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b10) |-> (map_tgt == 2'd0 && map_page[PAGE_W-1:1] == 2));
endmodule

// File: tb/sim_upper_window_mapper.sv
module sim_upper_window_mapper;
  localparam int PERIOD = 10;
  localparam int NV = 17;
  // {wdata, limit, addr, hit, tgt, page}
  localparam logic [33:0] VEC [NV] = '{
    {8'h00, 1'b0, 16'hC000, 1'b1, 2'd0, 6'd0},
    {8'h00, 1'b0, 16'hE123, 1'b1, 2'd0, 6'd1},
    {8'h03, 1'b0, 16'hC000, 1'b1, 2'd0, 6'd6},
    {8'h03, 1'b0, 16'hF000, 1'b1, 2'd0, 6'd7},
    {8'h05, 1'b0, 16'hC000, 1'b1, 2'd1, 6'd0},
    {8'h05, 1'b0, 16'hE000, 1'b1, 2'd1, 6'd1},
    {8'h07, 1'b0, 16'hC000, 1'b1, 2'd1, 6'd2},
    {8'h07, 1'b0, 16'hFFFF, 1'b1, 2'd1, 6'd3},
    {8'h45, 1'b0, 16'hC000, 1'b1, 2'd0, 6'd26},
    {8'hC7, 1'b0, 16'hE000, 1'b1, 2'd0, 6'd63},
    {8'hC7, 1'b1, 16'hE000, 1'b1, 2'd1, 6'd3},
    {8'h86, 1'b0, 16'hD000, 1'b1, 2'd0, 6'd44},
    {8'h86, 1'b1, 16'hD000, 1'b1, 2'd0, 6'd12},
    {8'h38, 1'b0, 16'hC000, 1'b1, 2'd0, 6'd0},
    {8'hFF, 1'b0, 16'h8000, 1'b1, 2'd0, 6'd4},
    {8'hFF, 1'b0, 16'hBFFF, 1'b1, 2'd0, 6'd5},
    {8'hFF, 1'b0, 16'h7FFF, 1'b0, 2'd0, 6'd0}
  };

  logic clk = 0, rst_n = 0, io_wr = 0, limit_128k = 0;
  logic [15:0] io_addr = 0, cpu_addr = 0;
  logic [7:0] io_wdata = 0;
  logic side_lo_en = 0, side_hi_en = 0;
  logic [5:0] side_lo_page = 0, side_hi_page = 0;
  logic map_hit;
  logic [1:0] map_tgt;
  logic [5:0] map_page;
  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  upper_window_mapper u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .limit_128k(limit_128k), .cpu_addr(cpu_addr), .side_lo_en(side_lo_en),
    .side_lo_page(side_lo_page), .side_hi_en(side_hi_en), .side_hi_page(side_hi_page),
    .map_hit(map_hit), .map_tgt(map_tgt), .map_page(map_page)
  );

  task automatic port_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic check(input string req, input logic h, input logic [1:0] t, input logic [5:0] p);
    #1;
    total++;
    if (map_hit !== h || map_tgt !== t || map_page !== p) begin
      bad++;
      $display("FAIL %s: got hit=%0d tgt=%0d page=%0d, want hit=%0d tgt=%0d page=%0d",
               req, map_hit, map_tgt, map_page, h, t, p);
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cpu_addr = 16'hC000; check("R1", 1, 0, 0);
    cpu_addr = 16'hE000; check("R1", 1, 0, 1);
    rst_n = 1;
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      port_write(16'h7FFD, VEC[i][33:26]);
      limit_128k = VEC[i][25];
      cpu_addr = VEC[i][24:9];
      check("R3/R4/R5/R6/R8 table", VEC[i][8], VEC[i][7:6], VEC[i][5:0]);
    end
    limit_128k = 0;

    // R2: write to a different port is ignored
    port_write(16'h7FFD, 8'h03);
    port_write(16'h7FFC, 8'h07);
    port_write(16'hFFFD, 8'h07);
    cpu_addr = 16'hC000; check("R2", 1, 0, 6);
    // R2: strobe low ignored
    @(negedge clk); io_addr = 16'h7FFD; io_wdata = 8'h05; io_wr = 0;
    @(negedge clk); check("R2", 1, 0, 6);

    // R5: flag acts live, no new write
    port_write(16'h7FFD, 8'hC7);
    cpu_addr = 16'hE000; check("R5", 1, 0, 63);
    limit_128k = 1; check("R5", 1, 1, 3);
    limit_128k = 0; check("R5", 1, 0, 63);

    // R9: address change within a cycle
    port_write(16'h7FFD, 8'h01);
    cpu_addr = 16'hC000; check("R9", 1, 0, 2);
    cpu_addr = 16'hE000; check("R9", 1, 0, 3);
    cpu_addr = 16'hA000; check("R9", 1, 0, 5);
    cpu_addr = 16'h4000; check("R8", 0, 0, 0);

    // R7: overlays per slot
    port_write(16'h7FFD, 8'h05);
    side_lo_en = 1; side_lo_page = 6'd33; side_hi_page = 6'd41;
    cpu_addr = 16'hC000; check("R7", 1, 2, 33);
    cpu_addr = 16'hE000; check("R7", 1, 1, 1);
    side_lo_en = 0; side_hi_en = 1;
    check("R7", 1, 2, 41);
    cpu_addr = 16'hC000; check("R7", 1, 1, 0);
    cpu_addr = 16'h8000; check("R7/R6", 1, 0, 4);
    side_hi_en = 0;

    // R1: reset again restores page 0
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    cpu_addr = 16'hC000; check("R1", 1, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule